// File: doc/BRIEF.md
# Lag-Group Weighted Covariance Sequencer

This controller produces one entry of a long-run covariance estimate by driving an external lag-parallel correlation engine. Each engine pass handles a group of `C` consecutive lags and returns `C` partial lag sums. The sequencer steps a group index from zero up to the last group and launches one pass per group. After a pass it multiplies the returned sums, one per clock, by the matching lag weights and adds the products into a wide signed accumulator.

The lag-zero term is folded into the weighted sum with a fixed half weight. Lags 1 to H take their weights from a table that is written through a simple write port. Lags above H, which pad out the last group, always get weight zero. As a result the engine always computes a full group of lags and no lag needs its own special case. All values are signed fixed point. Weights have `WF` fractional bits, so the accumulated result carries `WF` fractional bits as well. Forming the final symmetric estimate from this entry and its transpose partner is left to the consumer.

Top module: `lag_group_wsum`

## Requirements
- R1: After reset, `busy`, `done` and `eng_start` are low and `psi` is zero.
- R2: A `start` pulse while idle captures `cfg_lags` (H, at most MAXH) and `cfg_len` (T). It then launches exactly floor(H/C)+1 passes, which equals ceil((H+1)/C), with `eng_group` stepping 0, 1, 2, … in order.
- R3: During the one-cycle `eng_start` of group g, `eng_cycles` equals T − g·C.
- R4: Each pass raises `eng_start` for one cycle only. No further pass is launched until `eng_done` has been seen, and `eng_sums` are read only in the cycle in which `eng_done` is high. Lane k (bits k·DW upward, DW wide, signed) holds the sum for lag g·C+k.
- R5: Lag 0 is weighted by one half, which is 2^(WF−1) in the weight format, whatever the table holds.
- R6: Lag h with 1 ≤ h ≤ H is weighted by table entry h−1, written by `wt_we` with `wt_addr` = h−1 and signed `wt_data`.
- R7: Lags above H in the last group are weighted by zero, whatever the table or the engine sums hold.
- R8: At completion, `psi` equals the sum over all passes and lanes of weight(lag)·sum(lag), as a signed integer with WF fractional bits.
- R9: `done` rises when the last product has been added. `done` and `psi` then hold until the next `start`, and a `start` while busy is ignored.
- R10: `busy` is high from the cycle after an accepted `start` until `done` rises, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new entry (accepted only when idle) |
| cfg_lags | input | HW | Lag truncation H |
| cfg_len | input | TW | Series length T |
| wt_we | input | 1 | Weight table write enable |
| wt_addr | input | TAW | Table index (lag − 1) |
| wt_data | input | WW | Signed weight, WF fractional bits |
| eng_start | output | 1 | One-cycle launch of an engine pass |
| eng_group | output | GW | Group index of the current pass |
| eng_cycles | output | TW | Streaming length of the current pass |
| eng_done | input | 1 | Engine pass finished, sums valid |
| eng_sums | input | C·DW | C signed partial lag sums |
| busy | output | 1 | Sequencer running |
| done | output | 1 | Result valid and held |
| psi | output | AW | Signed accumulated weighted sum |

## Verification
The weighted sum is exercised with lag counts that fill the groups exactly (H+1 a multiple of C), that leave a padded last group, that reduce to the lag-zero term alone, and that reach the maximum table size. Together these separate a wrong group count from a wrong weight selection. In the padded and lag-zero cases, large engine sums and nonzero table entries are placed at the lags above H, so any leak of the padding into `psi` shows up. A behavioural engine answers each pass after a delay that varies from pass to pass, checks the group order and the streaming length, and drives garbage on the sums outside the `eng_done` cycle. A `start` pulse with a different configuration is injected in the middle of a run to confirm that it is ignored.

// File: rtl/lag_group_wsum.sv
module lag_group_wsum #(
  parameter int C    = 4,
  parameter int DW   = 24,
  parameter int WW   = 16,
  parameter int WF   = 14,
  parameter int MAXH = 31,
  parameter int TW   = 16,
  localparam int HW  = $clog2(MAXH + 1),
  localparam int TAW = $clog2(MAXH),
  localparam int LW  = $clog2(MAXH + C + 1),
  localparam int GW  = $clog2(MAXH / C + 2),
  localparam int KW  = $clog2(C),
  localparam int AW  = DW + WW + LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [HW-1:0]        cfg_lags,
  input  logic [TW-1:0]        cfg_len,
  input  logic                 wt_we,
  input  logic [TAW-1:0]       wt_addr,
  input  logic signed [WW-1:0] wt_data,
  output logic                 eng_start,
  output logic [GW-1:0]        eng_group,
  output logic [TW-1:0]        eng_cycles,
  input  logic                 eng_done,
  input  logic [C*DW-1:0]      eng_sums,
  output logic                 busy,
  output logic                 done,
  output logic signed [AW-1:0] psi
);

  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_MAC} st_t;

  st_t                  st;
  logic                 done_q;
  logic [GW-1:0]        g_q, g_last;
  logic [HW-1:0]        h_q;
  logic [TW-1:0]        len_q;
  logic [KW-1:0]        k_q;
  logic signed [DW-1:0] sums_q [C];
  logic signed [WW-1:0] wtab [MAXH];
  logic signed [AW-1:0] acc;

  logic [LW-1:0]        lag;
  logic signed [WW-1:0] w;
  logic signed [AW-1:0] wx, sx;

  assign lag = LW'(g_q) * LW'(C) + LW'(k_q);

  always_comb begin
    if (lag == '0)                w = WW'(1 << (WF - 1));
    else if (lag <= LW'(h_q))     w = wtab[TAW'(lag - 1'b1)];
    else                          w = '0;
  end

  assign wx = AW'(w);
  assign sx = AW'(sums_q[k_q]);

  always_ff @(posedge clk)
    if (wt_we) wtab[wt_addr] <= wt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done_q <= 1'b0;
      g_q    <= '0;
      g_last <= '0;
      h_q    <= '0;
      len_q  <= '0;
      k_q    <= '0;
      acc    <= '0;
      for (int i = 0; i < C; i++) sums_q[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          h_q    <= cfg_lags;
          len_q  <= cfg_len;
          g_last <= GW'(cfg_lags / HW'(C));
          g_q    <= '0;
          acc    <= '0;
          done_q <= 1'b0;
          st     <= S_LAUNCH;
        end
        S_LAUNCH: st <= S_WAIT;
        S_WAIT: if (eng_done) begin
          for (int i = 0; i < C; i++) sums_q[i] <= eng_sums[i*DW +: DW];
          k_q <= '0;
          st  <= S_MAC;
        end
        S_MAC: begin
          acc <= acc + wx * sx;
          if (k_q == KW'(C - 1)) begin
            if (g_q == g_last) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              g_q <= g_q + 1'b1;
              st  <= S_LAUNCH;
            end
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign eng_start  = (st == S_LAUNCH);
  assign eng_group  = g_q;
  assign eng_cycles = len_q - TW'(g_q) * TW'(C);
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign psi        = acc;

endmodule

// File: rtl/lag_group_wsum_chk.sv
module lag_group_wsum_chk #(
  parameter int C  = 4,
  parameter int GW = 3,
  parameter int TW = 16,
  parameter int AW = 47
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          eng_start,
  input logic [GW-1:0] eng_group,
  input logic [TW-1:0] eng_cycles,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] psi
);

  logic [TW-1:0] prev_cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         prev_cyc <= '0;
    else if (eng_start) prev_cyc <= eng_cycles;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !eng_start && psi == '0));

  // R3
  group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_group != '0) |-> (int'(eng_cycles) + C == int'(prev_cyc)));

  // R4
  single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R9
  psi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(psi) && done));

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

bind lag_group_wsum lag_group_wsum_chk #(.C(C), .GW(GW), .TW(TW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .eng_start(eng_start),
  .eng_group(eng_group), .eng_cycles(eng_cycles), .busy(busy),
  .done(done), .psi(psi)
);

// File: tb/lag_group_wsum_tb_top.sv
module lag_group_wsum_tb_top;
  localparam int PERIOD = 10;
  localparam int C = 4, DW = 24, WW = 16, WF = 14, MAXH = 31, TW = 16;
  localparam int HW = $clog2(MAXH + 1);
  localparam int TAW = $clog2(MAXH);
  localparam int LW = $clog2(MAXH + C + 1);
  localparam int GW = $clog2(MAXH / C + 2);
  localparam int AW = DW + WW + LW + 1;

  logic clk = 0, rst_n = 0, start = 0, wt_we = 0, eng_done = 0;
  logic [HW-1:0] cfg_lags = '0;
  logic [TW-1:0] cfg_len = '0;
  logic [TAW-1:0] wt_addr = '0;
  logic signed [WW-1:0] wt_data = '0;
  logic [C*DW-1:0] eng_sums = '0;
  logic eng_start, busy, done;
  logic [GW-1:0] eng_group;
  logic [TW-1:0] eng_cycles;
  logic signed [AW-1:0] psi;

  lag_group_wsum #(.C(C), .DW(DW), .WW(WW), .WF(WF), .MAXH(MAXH), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_lags(cfg_lags), .cfg_len(cfg_len),
    .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data), .eng_start(eng_start),
    .eng_group(eng_group), .eng_cycles(eng_cycles), .eng_done(eng_done),
    .eng_sums(eng_sums), .busy(busy), .done(done), .psi(psi));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cur_h = 0, cur_t = 0, mode = 0, passes = 0, exp_g = 0;
  int tab [1:MAXH];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sval(input int lag);
    int v;
    v = ((lag * (1231 + mode * 977) + mode * 311) % 400000) - 150000;
    if (lag > cur_h) v = v + 3000000;
    return v;
  endfunction

  function automatic int wexp(input int lag);
    if (lag == 0) return 1 << (WF - 1);
    if (lag <= cur_h) return tab[lag];
    return 0;
  endfunction

  // behavioural engine
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_start) begin
        int g;
        g = int'(eng_group);
        chk(g == exp_g, "R2 group order", g, exp_g);
        chk(int'(eng_cycles) == cur_t - g * C, "R3 pass length", eng_cycles, cur_t - g * C);
        passes++;
        exp_g++;
        eng_sums = {(C*DW/2){2'b10}};
        for (int d = 0; d < 1 + (g % 3); d++) begin
          @(negedge clk);
          chk(!eng_start, "R4 relaunch while waiting", eng_start, 0);
        end
        for (int k = 0; k < C; k++) eng_sums[k*DW +: DW] = DW'(sval(g * C + k));
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        eng_sums = {(C*DW/2){2'b01}};
      end
    end
  end

  task automatic load_table(input int h);
    for (int i = 1; i <= MAXH; i++) begin
      tab[i] = (i <= h) ? ((16384 * (h + 1 - i)) / (h + 1)) : (1000 + 37 * i);
      @(negedge clk);
      wt_we = 1; wt_addr = TAW'(i - 1); wt_data = WW'(tab[i]);
    end
    @(negedge clk);
    wt_we = 0;
  endtask

  task automatic run_case(input int h, input int t, input int m, input bit poke, input string tag);
    longint e;
    longint held;
    int n;
    load_table(h);
    cur_h = h; cur_t = t; mode = m; passes = 0; exp_g = 0;
    e = 0;
    for (int lag = 0; lag < (h / C + 1) * C; lag++) e += longint'(wexp(lag)) * longint'(sval(lag));
    @(negedge clk);
    cfg_lags = HW'(h); cfg_len = TW'(t); start = 1;
    @(negedge clk);
    start = 0; cfg_lags = '0; cfg_len = '0;
    chk(busy && !done, {tag, " R10 busy after start"}, busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_lags = 2; cfg_len = 7; start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, {tag, " R9 done reached"}, done, 1);
    chk(!busy, {tag, " R10 busy low at done"}, busy, 0);
    chk(passes == h / C + 1, {tag, " R2 pass count"}, passes, h / C + 1);
    chk(longint'(psi) == e, {tag, " R8 weighted sum"}, psi, e);
    held = longint'(psi);
    repeat (6) @(negedge clk);
    chk(done && longint'(psi) == held, {tag, " R9 result held"}, psi, held);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !eng_start && psi == '0, "R1 reset state", psi, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !eng_start, "R1 idle after reset", busy, 0);
    run_case(7, 100, 0, 0, "full groups R5 R6");
    run_case(5, 50, 1, 0, "padded group R7");
    run_case(0, 10, 2, 0, "lag zero only R5");
    run_case(31, 200, 3, 0, "max table R6");
    run_case(9, 60, 4, 1, "start while busy R9");
    run_case(13, 80, 5, 0, "odd padding R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule